// File: doc/BRIEF.md
# Parallel Display Bus Write Master

This block is the host side of an 8-bit parallel bus that feeds a display controller. The host hands it one request at a time over a valid/ready handshake. A request is a register-index write, a parameter write, or a compound command that sends an index byte and then one parameter byte. The block turns each request into pin activity: an active-low chip select, a register-select line, a write strobe, a read strobe and the data byte. All timing is counted in system clock cycles.

A static mode input picks one of two signalling styles. In the first, the write pin is an active-low strobe and the read pin sits high. In the second, the read pin becomes an active-high enable and the write pin becomes a direction line held low for writing while chip select is low. Strobe active width and minimum inactive width are parameters. Select, register-select and data are settled one clock before the strobe goes active and held one clock after it goes inactive.

Top module: `pbus_wr_master`

## Requirements
- R1: After reset, csN is high, idle and reqReady are high, and the strobes are inactive: wrStrobe high, and rdStrobe high when mode68 is 0 or low when mode68 is 1.
- R2: A request with reqKind 2'b00 makes exactly one write with regSel low and dataOut equal to reqIndex.
- R3: A request with reqKind 2'b01 makes exactly one write with regSel high and dataOut equal to reqValue.
- R4: A request with reqKind[1] set (2'b10 or 2'b11) makes an index write (regSel low, reqIndex) followed by a parameter write (regSel high, reqValue), both inside one csN-low window; every request yields exactly one csN-low window.
- R5: With mode68 at 0, the strobe is wrStrobe active low and rdStrobe stays high at all times.
- R6: With mode68 at 1, the strobe is rdStrobe active high, and wrStrobe is low exactly while csN is low.
- R7: Each strobe stays active for exactly LOW_CYC clock cycles.
- R8: Between any two strobes the strobe stays inactive for at least HIGH_CYC cycles, also across back-to-back requests.
- R9: csN is low, and regSel and dataOut are unchanged, for at least one cycle before the strobe goes active, through the whole active phase, and for one cycle after it goes inactive.
- R10: reqReady falls in the cycle after a request is accepted and rises again only in the cycle in which the pins show the hold cycle of the last strobe (csN low, strobe inactive).
- R11: idle is high exactly when reqReady is high and csN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| mode68 | input | 1 | Signalling style: 0 strobe-low style, 1 enable plus direction style; change only in reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqKind | input | 2 | 00 index, 01 parameter, 1x command |
| reqIndex | input | 8 | Register index byte |
| reqValue | input | 8 | Parameter byte |
| csN | output | 1 | Chip select, active low |
| regSel | output | 1 | Low for index, high for parameter |
| wrStrobe | output | 1 | Write strobe, or direction line in mode68 |
| rdStrobe | output | 1 | Read strobe held high, or enable in mode68 |
| dataOut | output | 8 | Bus data |
| idle | output | 1 | No transfer in progress |

## Verification
Two things can land in the same cycle: acceptance of a new request in the very cycle reqReady returns, while the previous strobe's inactive time is still short, and the stretch of the setup phase that enforces the inactive width. The bench provokes this by holding reqValid high across a long random run of requests so each one is taken the first cycle ready is high, including commands whose second phase follows its own hold cycle. A pin monitor judges every strobe against the width, gap, setup and hold rules and collects the written bytes, which are compared with a list built from the requests.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ACT   = 2'd2,
    ST_HOLD  = 2'd3
  } busState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch request bytes this cycle
    logic csAct;       // select the target
    logic strobeAct;   // strobe active phase
    logic paramPhase;  // 1: parameter byte, regSel high
  } busCtl_t;

endpackage

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int LOW_CYC  = 5,
  parameter int HIGH_CYC = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  output logic       reqReady,
  output busCtl_t    ctl
);

  localparam int LW = $clog2(LOW_CYC + 1);
  localparam int HW = $clog2(HIGH_CYC + 1);
  localparam logic [LW-1:0] LOW_LAST = LW'(LOW_CYC - 1);
  localparam logic [HW-1:0] GAP_LAST = HW'(HIGH_CYC - 1);
  localparam logic [HW-1:0] GAP_SAT  = HW'(HIGH_CYC);

  busState_e state, stateNxt;
  logic [LW-1:0] lowCnt;
  logic [HW-1:0] inactCnt;
  logic paramPhase;
  logic pending;
  logic accept;

  assign accept   = reqValid && (state == ST_IDLE);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (accept) stateNxt = ST_SETUP;
      ST_SETUP: if (inactCnt >= GAP_LAST) stateNxt = ST_ACT;
      ST_ACT:   if (lowCnt == LOW_LAST) stateNxt = ST_HOLD;
      ST_HOLD:  stateNxt = pending ? ST_SETUP : ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      lowCnt     <= '0;
      inactCnt   <= GAP_SAT;
      paramPhase <= 1'b0;
      pending    <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_ACT) begin
        inactCnt <= '0;
        lowCnt   <= (stateNxt == ST_ACT) ? lowCnt + 1'b1 : '0;
      end else begin
        lowCnt <= '0;
        if (inactCnt != GAP_SAT) inactCnt <= inactCnt + 1'b1;
      end
      if (accept) begin
        paramPhase <= (reqKind == 2'b01);
        pending    <= reqKind[1];
      end else if (state == ST_HOLD && pending) begin
        paramPhase <= 1'b1;
        pending    <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.capture    = accept;
    ctl.csAct      = (state != ST_IDLE);
    ctl.strobeAct  = (state == ST_ACT);
    ctl.paramPhase = paramPhase;
  end

  // R10: no second acceptance while a transfer is running
  assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R4: compound request moves on to its parameter phase after the index hold
  assert_cmd_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && pending) |=> (state == ST_SETUP && paramPhase && !reqReady));

endmodule

// File: rtl/pbus_datapath.sv
module pbus_datapath
  import pbus_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int LOW_CYC  = 5,
  parameter int HIGH_CYC = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mode68,
  input  busCtl_t          ctl,
  input  logic [WIDTH-1:0] reqIndex,
  input  logic [WIDTH-1:0] reqValue,
  output logic             csN,
  output logic             regSel,
  output logic             wrStrobe,
  output logic             rdStrobe,
  output logic [WIDTH-1:0] dataOut
);

  localparam int LW = $clog2(LOW_CYC + 1);
  localparam int HW = $clog2(HIGH_CYC + 1);
  localparam logic [LW-1:0] LOW_SAT  = LW'(LOW_CYC);
  localparam logic [HW-1:0] HIGH_SAT = HW'(HIGH_CYC);

  logic [WIDTH-1:0] idxReg, valReg;
  logic strobeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg <= '0;
      valReg <= '0;
    end else if (ctl.capture) begin
      idxReg <= reqIndex;
      valReg <= reqValue;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN     <= 1'b1;
      strobeQ <= 1'b0;
      regSel  <= 1'b0;
      dataOut <= '0;
    end else begin
      csN     <= ~ctl.csAct;
      strobeQ <= ctl.strobeAct;
      regSel  <= ctl.paramPhase;
      dataOut <= ctl.paramPhase ? valReg : idxReg;
    end
  end

  // Pin mapping per signalling style (mode68 is static)
  assign wrStrobe = mode68 ? csN : ~strobeQ;
  assign rdStrobe = mode68 ? strobeQ : 1'b1;

  // Run-length counters that feed the timing checks below
  logic [LW-1:0] actRun;
  logic [HW-1:0] inactRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actRun   <= '0;
      inactRun <= HIGH_SAT;
    end else if (strobeQ) begin
      inactRun <= '0;
      if (actRun != LOW_SAT) actRun <= actRun + 1'b1;
    end else begin
      actRun <= '0;
      if (inactRun != HIGH_SAT) inactRun <= inactRun + 1'b1;
    end
  end

  assert_strobe_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobeQ) |-> ($past(actRun) == LW'(LOW_CYC - 1)));

  assert_strobe_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeQ) |-> ($past(inactRun) >= HW'(HIGH_CYC - 1)));

  assert_setup_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeQ) |-> (!$past(csN) && $stable(dataOut) && $stable(regSel)));

  assert_steady_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobeQ && $past(strobeQ)) |-> (!csN && $stable(dataOut) && $stable(regSel)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobeQ) |-> (!csN && $stable(dataOut) && $stable(regSel)));

endmodule

// File: rtl/pbus_wr_master.sv
module pbus_wr_master
  import pbus_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int LOW_CYC  = 5,
  parameter int HIGH_CYC = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mode68,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqKind,
  input  logic [WIDTH-1:0] reqIndex,
  input  logic [WIDTH-1:0] reqValue,
  output logic             csN,
  output logic             regSel,
  output logic             wrStrobe,
  output logic             rdStrobe,
  output logic [WIDTH-1:0] dataOut,
  output logic             idle
);

  busCtl_t ctl;

  pbus_ctrl #(
    .LOW_CYC (LOW_CYC),
    .HIGH_CYC(HIGH_CYC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqKind (reqKind),
    .reqReady(reqReady),
    .ctl     (ctl)
  );

  pbus_datapath #(
    .WIDTH   (WIDTH),
    .LOW_CYC (LOW_CYC),
    .HIGH_CYC(HIGH_CYC)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .mode68  (mode68),
    .ctl     (ctl),
    .reqIndex(reqIndex),
    .reqValue(reqValue),
    .csN     (csN),
    .regSel  (regSel),
    .wrStrobe(wrStrobe),
    .rdStrobe(rdStrobe),
    .dataOut (dataOut)
  );

  assign idle = reqReady && csN;

endmodule

// File: tb/sim_pbus_wr_master.sv
module sim_pbus_wr_master;

  localparam int CLK_PERIOD = 10;
  localparam int LOW_CYC    = 5;
  localparam int HIGH_CYC   = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mode68 = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'b00;
  logic [7:0] reqIndex = 8'h00;
  logic [7:0] reqValue = 8'h00;
  logic reqReady, csN, regSel, wrStrobe, rdStrobe, idle;
  logic [7:0] dataOut;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pbus_wr_master #(.WIDTH(8), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u0 (
    .clk(clk), .rstN(rstN), .mode68(mode68), .reqValid(reqValid),
    .reqReady(reqReady), .reqKind(reqKind), .reqIndex(reqIndex),
    .reqValue(reqValue), .csN(csN), .regSel(regSel), .wrStrobe(wrStrobe),
    .rdStrobe(rdStrobe), .dataOut(dataOut), .idle(idle)
  );

  int nChecks = 0;
  int nErrors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected and observed write lists: {regSel, data}
  logic [8:0] expW[0:255];
  logic [8:0] obsW[0:255];
  int expCnt, obsCnt, reqCnt, windows;
  int errSetup, errStab, errHold, errWidth, errGap, errPin, errReady, errIdle;

  function automatic void pushExp(input logic [1:0] k, input logic [7:0] i, input logic [7:0] v);
    if (k[1]) begin
      expW[expCnt] = {1'b0, i}; expW[expCnt + 1] = {1'b1, v}; expCnt += 2;
    end else if (k == 2'b01) begin
      expW[expCnt] = {1'b1, v}; expCnt++;
    end else begin
      expW[expCnt] = {1'b0, i}; expCnt++;
    end
  endfunction

  // Pin monitor, sampled away from the active edge
  bit monOn = 0;
  logic pAct, pCsN, pRs, pReady;
  logic [7:0] pData;
  int lowRun, inactRun;

  always @(negedge clk) begin
    if (monOn) begin
      logic act;
      act = mode68 ? rdStrobe : ~wrStrobe;
      if (act && !pAct) begin
        if (pCsN || csN || dataOut != pData || regSel != pRs) errSetup++;
        if (inactRun < HIGH_CYC) errGap++;
        lowRun = 1;
      end else if (act) begin
        lowRun++;
        if (csN || dataOut != pData || regSel != pRs) errStab++;
      end
      if (!act && pAct) begin
        if (obsCnt < 256) obsW[obsCnt] = {pRs, pData};
        obsCnt++;
        if (lowRun != LOW_CYC) errWidth++;
        if (csN || dataOut != pData || regSel != pRs) errHold++;
        inactRun = 1;
      end else if (!act && inactRun < 1000) inactRun++;
      if (mode68) begin
        if (wrStrobe != csN) errPin++;
      end else if (!rdStrobe) errPin++;
      if (!csN && pCsN) windows++;
      if (reqReady && !pReady && !(!csN && !act)) errReady++;
      if (idle != (csN && reqReady)) errIdle++;
      pAct = act; pCsN = csN; pRs = regSel; pData = dataOut; pReady = reqReady;
    end
  end

  task automatic clearBatch();
    expCnt = 0; obsCnt = 0; reqCnt = 0; windows = 0;
    errSetup = 0; errStab = 0; errHold = 0; errWidth = 0;
    errGap = 0; errPin = 0; errReady = 0; errIdle = 0;
  endtask

  task automatic doReset(input logic m);
    monOn = 0;
    reqValid = 1'b0;
    rstN = 1'b0;
    mode68 = m;
    repeat (4) @(negedge clk);
    // R1: reset state at the pins
    check(csN === 1'b1, "R1 csN", csN, 1);
    check(idle === 1'b1 && reqReady === 1'b1, "R1 idle/ready", {idle, reqReady}, 3);
    check(wrStrobe === 1'b1, "R1 wrStrobe", wrStrobe, 1);
    check(rdStrobe === !m, "R1 rdStrobe", rdStrobe, !m);
    rstN = 1'b1;
    @(negedge clk);
    pAct = 0; pCsN = 1; pRs = regSel; pData = dataOut; pReady = reqReady;
    lowRun = 0; inactRun = 1000;
    clearBatch();
    monOn = 1;
  endtask

  task automatic runReq(input logic [1:0] k, input logic [7:0] i, input logic [7:0] v);
    bit took;
    reqValid = 1'b1; reqKind = k; reqIndex = i; reqValue = v;
    took = 0;
    while (!took) begin
      took = reqReady;
      @(negedge clk);
    end
    reqValid = 1'b0;
    check(reqReady === 1'b0, "R10 ready low after accept", reqReady, 0);
    pushExp(k, i, v);
    reqCnt++;
  endtask

  task automatic finishBatch(input string name, input string tag);
    while (!idle) @(negedge clk);
    repeat (3) @(negedge clk);
    check(obsCnt == expCnt, {tag, " write count ", name}, obsCnt, expCnt);
    for (int n = 0; n < expCnt && n < obsCnt && n < 256; n++)
      check(obsW[n] == expW[n], {tag, " write content ", name}, obsW[n], expW[n]);
    check(windows == reqCnt, {"R4 select windows ", name}, windows, reqCnt);
    check(errSetup == 0 && errStab == 0 && errHold == 0, {"R9 setup/hold ", name},
          errSetup + errStab + errHold, 0);
    check(errWidth == 0, {"R7 strobe width ", name}, errWidth, 0);
    check(errGap == 0, {"R8 strobe gap ", name}, errGap, 0);
    check(errPin == 0, {mode68 ? "R6" : "R5", " pin style ", name}, errPin, 0);
    check(errReady == 0, {"R10 ready return ", name}, errReady, 0);
    check(errIdle == 0, {"R11 idle ", name}, errIdle, 0);
    clearBatch();
  endtask

  task automatic runMode(input logic m);
    int seedVal;
    doReset(m);
    runReq(2'b00, 8'h2C, 8'h00);
    finishBatch("index", "R2");
    runReq(2'b01, 8'h00, 8'hA5);
    finishBatch("param", "R3");
    runReq(2'b10, 8'h00, 8'hFF);
    runReq(2'b11, 8'h81, 8'h7E);
    finishBatch("commands", "R4");
    // back-to-back: valid held, each taken on the first ready cycle
    runReq(2'b00, 8'hFF, 8'h00);
    runReq(2'b10, 8'h01, 8'h80);
    runReq(2'b01, 8'h00, 8'h55);
    finishBatch("back-to-back", "R8");
    seedVal = $urandom(m ? 32'd977 : 32'd311);
    for (int n = 0; n < 40; n++)
      runReq(2'($urandom % 4), 8'($urandom), 8'($urandom));
    finishBatch("random", "R2");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nErrors++;
    nChecks++;
    $display("FAIL watchdog: run hung actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin : mainSeq
    clearBatch();
    runMode(1'b0);
    runMode(1'b1);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule